// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM whose data bus never needs an idle cycle between a read and a write. Every control input, the address and the byte enables are registered on the rising clock edge. Read data flows through the array and appears in the same cycle that follows the edge that captured the read. Write data is taken one accepted edge after its command and is committed then with the byte enables captured alongside the command. Because of that one-cycle offset, a read placed right after a write uses the bus slot that the write data does not need, in either order.

A command either starts a new operation at an external address or continues the previous one through a 2-bit burst counter. The counter steps in linear or interleaved order and wraps inside an aligned group of four words. A clock-skip input freezes the whole block for an edge. A sleep input deselects it. An asynchronous output enable gates only the output drive.

Top module: `ft_sram`

## Requirements
- R1: A new command is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Every other combination, with `start_n`=0, is a deselect cycle that neither reads nor writes.
- R2: With `start_n`=0 and the device selected, a command starts at `addr`. It reads when `is_read`=1 and writes when `is_read`=0. Read data for the captured address is on `q` with `q_drv`=1 in the cycle right after that edge.
- R3: With `start_n`=1 after an active command, the same operation continues. With `order_il`=0, beat k addresses the group base plus ((start low two bits + k) mod 4).
- R4: With `order_il`=1, beat k addresses the group base plus (start low two bits XOR k).
- R5: A burst continued past its fourth beat wraps to its starting word. A continue issued after a deselect or sleep cycle is itself a deselect.
- R6: On an edge with `edge_skip`=1, nothing is captured. Burst state, pending write, memory and outputs hold.
- R7: Bit i of `lane_we_n` enables byte i (bits 8i+7..8i) of a write when low. A write with all four bits high changes nothing.
- R8: Write data is taken from `wdata` at the next edge with `edge_skip`=0 after the edge that accepted the write command.
- R9: Reads and writes follow each other in any order with no idle cycle. A read of the word written by the immediately preceding write returns the new data.
- R10: `out_en_n`=1 forces `q_drv`=0 and `q`=0 within the same cycle, and leaves internal state untouched.
- R11: While `sleep`=1, accepted edges act as deselects. New reads and writes are ignored and memory is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| edge_skip | input | 1 | 1 = ignore this clock edge |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| start_n | input | 1 | 0 = new command, 1 = continue burst |
| is_read | input | 1 | 1 = read, 0 = write (new commands) |
| lane_we_n | input | 4 | Active-low byte write enables |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data, one accepted edge after the command |
| order_il | input | 1 | 0 = linear burst order, 1 = interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Forces deselect while high |
| q | output | 32 | Read data, zero when not driven |
| q_drv | output | 1 | Output drive active |

## Verification
The bench writes a unique word everywhere and reads bursts from every start address in both orders. A counter that stepped the wrong way, or wrapped outside its group of four, would return a neighbouring word. Each of the sixteen byte-enable patterns is applied to one word. A swapped lane or a leaky abort would corrupt bytes that should stay. Alternating write and read sequences on the same address expose a design that reads before it commits. Skipped edges placed between a command and its data expose a design that takes data one edge early or lets state move during a skip. Select combinations, sleep, and continues after a deselect check that no stray operation issues.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       il);
    return il ? (start ^ beat) : (start + beat);
  endfunction

  // true when the three selects enable the device
  function automatic logic sel_ok(input logic a_n, input logic b,
                                  input logic c_n);
    return !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/ft_sram_ctrl.sv
module ft_sram_ctrl
  import ft_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             sleep,
  input  logic             start_n,
  input  logic             is_read,
  input  logic             order_il,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_we_n,
  output logic             issue_rd,
  output logic             issue_wr,
  output logic [AW-1:0]    issue_addr,
  output logic             rd_v,
  output logic [AW-1:0]    rd_a,
  output logic             wr_v,
  output logic [AW-1:0]    wr_a,
  output logic [LANES-1:0] wr_be
);

  op_e           burst_op;
  logic [AW-1:0] base;
  logic [1:0]    cnt;

  logic new_cmd, cont_cmd;
  op_e  new_op;

  always_comb begin
    new_cmd  = !start_n && sel_ok(sel_a_n, sel_b, sel_c_n) && !sleep;
    cont_cmd = start_n && (burst_op != OP_NONE) && !sleep;
    new_op   = is_read ? OP_READ : OP_WRITE;
    issue_rd = (new_cmd && is_read)  || (cont_cmd && burst_op == OP_READ);
    issue_wr = (new_cmd && !is_read) || (cont_cmd && burst_op == OP_WRITE);
    if (new_cmd) issue_addr = addr;
    else issue_addr = {base[AW-1:2], beat_lo(base[1:0], cnt + 2'd1, order_il)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_op <= OP_NONE;
      base     <= '0;
      cnt      <= '0;
      rd_v     <= 1'b0;
      rd_a     <= '0;
      wr_v     <= 1'b0;
      wr_a     <= '0;
      wr_be    <= '0;
    end else if (adv) begin
      if (new_cmd) begin
        burst_op <= new_op;
        base     <= addr;
        cnt      <= '0;
      end else if (cont_cmd) begin
        cnt      <= cnt + 2'd1;
      end else begin
        burst_op <= OP_NONE;
      end
      rd_v <= issue_rd;
      wr_v <= issue_wr;
      if (issue_rd) rd_a <= issue_addr;
      if (issue_wr) begin
        wr_a  <= issue_addr;
        wr_be <= ~lane_we_n;
      end
    end
  end

endmodule

// File: rtl/ft_sram_array.sv
module ft_sram_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] we_lane,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we_lane[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end

endmodule

// File: rtl/ft_sram_outdrv.sv
module ft_sram_outdrv #(
  parameter int DW = 32
) (
  input  logic          rd_v,
  input  logic          out_en_n,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] q,
  output logic          q_drv
);

  always_comb begin
    q_drv = rd_v && !out_en_n;
    q     = q_drv ? rdata : '0;
  end

endmodule

// File: rtl/ft_sram.sv
module ft_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_skip,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             start_n,
  input  logic             is_read,
  input  logic [LANES-1:0] lane_we_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             order_il,
  input  logic             out_en_n,
  input  logic             sleep,
  output logic [DW-1:0]    q,
  output logic             q_drv
);

  logic             adv;
  logic             issue_rd, issue_wr;
  logic [AW-1:0]    issue_addr;
  logic             rd_v, wr_v;
  logic [AW-1:0]    rd_a, wr_a;
  logic [LANES-1:0] wr_be;
  logic [LANES-1:0] we_lane;
  logic [DW-1:0]    rdata;

  assign adv     = !edge_skip;
  assign we_lane = (adv && wr_v) ? wr_be : '0;

  ft_sram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .sleep(sleep),
    .start_n(start_n), .is_read(is_read), .order_il(order_il),
    .addr(addr), .lane_we_n(lane_we_n),
    .issue_rd(issue_rd), .issue_wr(issue_wr), .issue_addr(issue_addr),
    .rd_v(rd_v), .rd_a(rd_a), .wr_v(wr_v), .wr_a(wr_a), .wr_be(wr_be)
  );

  ft_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we_lane(we_lane), .waddr(wr_a), .wdata(wdata),
    .raddr(rd_a), .rdata(rdata)
  );

  ft_sram_outdrv #(.DW(DW)) u_out (
    .rd_v(rd_v), .out_en_n(out_en_n), .rdata(rdata), .q(q), .q_drv(q_drv)
  );

endmodule

// File: rtl/ft_sram_chk.sv
module ft_sram_chk #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_skip,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             start_n,
  input logic             sleep,
  input logic             out_en_n,
  input logic             q_drv,
  input logic             issue_rd,
  input logic             issue_wr,
  input logic             rd_v,
  input logic [AW-1:0]    rd_a,
  input logic             wr_v,
  input logic [LANES-1:0] wr_be,
  input logic [LANES-1:0] we_lane
);

  AST_DESEL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && !(!sel_a_n && sel_b && !sel_c_n)) |-> !(issue_rd || issue_wr)); // R1

  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_rd && issue_wr)); // R2

  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_skip |=> ($stable(rd_v) && $stable(rd_a) && $stable(wr_v))); // R6

  AST_SKIP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    edge_skip |-> (we_lane == '0)); // R6

  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_v && wr_be == '0) |-> (we_lane == '0)); // R7

  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_skip && issue_wr) |=> wr_v); // R8

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !q_drv); // R10

  AST_SLEEP_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !(issue_rd || issue_wr)); // R11

endmodule

bind ft_sram ft_sram_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_skip(edge_skip),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .start_n(start_n), .sleep(sleep), .out_en_n(out_en_n), .q_drv(q_drv),
  .issue_rd(issue_rd), .issue_wr(issue_wr), .rd_v(rd_v), .rd_a(rd_a),
  .wr_v(wr_v), .wr_be(wr_be), .we_lane(we_lane)
);

// File: tb/ft_sram_tb.sv
module ft_sram_tb;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        edge_skip = 1'b0;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic        start_n = 1'b0, is_read = 1'b1;
  logic [3:0]  lane_we_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        order_il = 1'b0, out_en_n = 1'b0, sleep = 1'b0;
  logic [31:0] q;
  logic        q_drv;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] ref_mem [DEPTH];

  always #5 clk = ~clk;

  ft_sram #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .edge_skip(edge_skip),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .start_n(start_n), .is_read(is_read), .lane_we_n(lane_we_n),
    .addr(addr), .wdata(wdata), .order_il(order_il),
    .out_en_n(out_en_n), .sleep(sleep), .q(q), .q_drv(q_drv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_idle();
    sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
    start_n = 1'b0; is_read = 1'b1; lane_we_n = 4'hF;
  endtask

  task automatic set_new(input int a, input logic rd, input logic [3:0] be);
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    start_n = 1'b0; is_read = rd; addr = AW'(a); lane_we_n = ~be;
  endtask

  task automatic set_cont(input logic [3:0] be);
    start_n = 1'b1; lane_we_n = ~be;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  function automatic int beat_addr(input int base, input int k, input bit il);
    int lo = base % 4;
    int nl = il ? (lo ^ (k % 4)) : ((lo + k) % 4);
    return base - lo + nl;
  endfunction

  function automatic logic [31:0] pat(input int a, input int salt);
    return 32'((a + 1) * 32'h9E3779B1) ^ 32'(salt * 32'h01030507);
  endfunction

  task automatic write1(input int a, input logic [31:0] d, input logic [3:0] be);
    set_new(a, 1'b0, be); tick();
    set_idle(); wdata = d; tick();
    ref_mem[a] = merge(ref_mem[a], d, be);
  endtask

  task automatic read1(input string tag, input int a);
    set_new(a, 1'b1, 4'h0); tick();
    chk(tag, q, ref_mem[a]);
    chk(tag, 32'(q_drv), 32'd1);
    set_idle(); tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    set_idle();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R2 reset drive", 32'(q_drv), 32'd0);
    chk("R10 reset q", q, 32'd0);

    // fill every word (R2, R8)
    for (int a = 0; a < DEPTH; a++) write1(a, pat(a, 0), 4'hF);
    for (int a = 0; a < DEPTH; a += 7) read1("R2 single read", a);

    // burst reads from every start, both orders, five beats (R3 R4 R5)
    for (int il = 0; il < 2; il++) begin
      order_il = il[0];
      for (int s = 0; s < DEPTH; s++) begin
        set_new(s, 1'b1, 4'h0); tick();
        chk(il ? "R4 beat0" : "R3 beat0", q, ref_mem[s]);
        for (int k = 1; k < 5; k++) begin
          set_cont(4'h0); tick();
          chk(k == 4 ? "R5 wrap" : (il ? "R4 beat" : "R3 beat"), q, ref_mem[beat_addr(s, k, il[0])]);
        end
        set_idle(); tick();
      end
    end

    // burst writes in both orders, then single reads (R3 R4 R8)
    for (int il = 0; il < 2; il++) begin
      order_il = il[0];
      for (int s = 20; s < 24; s++) begin
        set_new(s, 1'b0, 4'hF); tick();
        for (int k = 1; k < 4; k++) begin
          set_cont(4'hF); wdata = pat(s, 10 + k - 1 + 4 * il); tick();
          ref_mem[beat_addr(s, k - 1, il[0])] = pat(s, 10 + k - 1 + 4 * il);
        end
        set_idle(); wdata = pat(s, 13 + 4 * il); tick();
        ref_mem[beat_addr(s, 3, il[0])] = pat(s, 13 + 4 * il);
        for (int w = 20; w < 24; w++) read1(il ? "R4 burst write" : "R3 burst write", w);
      end
    end
    order_il = 1'b0;

    // byte lanes and abort (R7)
    for (int be = 0; be < 16; be++) begin
      write1(10, pat(be, 77), 4'(be));
      read1("R7 lane merge", 10);
    end

    // back-to-back both orders, same-address coherence (R9)
    set_new(30, 1'b0, 4'hF); tick();
    set_new(30, 1'b1, 4'h0); wdata = 32'hC0DE0001; tick();
    ref_mem[30] = 32'hC0DE0001;
    chk("R9 write->read same addr", q, 32'hC0DE0001);
    set_new(31, 1'b0, 4'h3); tick();
    chk("R9 read->write drive off", 32'(q_drv), 32'd0);
    set_new(29, 1'b1, 4'h0); wdata = 32'hC0DE0002; tick();
    ref_mem[31] = merge(ref_mem[31], 32'hC0DE0002, 4'h3);
    chk("R9 write->read other addr", q, ref_mem[29]);
    set_new(31, 1'b1, 4'h0); tick();
    chk("R9 read after merged write", q, ref_mem[31]);
    set_idle(); tick();

    // skipped edges (R6 R8)
    set_new(34, 1'b1, 4'h0); tick();
    chk("R6 pre-skip", q, ref_mem[34]);
    edge_skip = 1'b1; set_new(40, 1'b1, 4'h0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 held q", q, ref_mem[34]);
      chk("R6 held drive", 32'(q_drv), 32'd1);
    end
    edge_skip = 1'b0; set_cont(4'h0); tick();
    chk("R6 resume beat", q, ref_mem[35]);
    set_cont(4'h0); tick();
    chk("R6 resume wrap", q, ref_mem[32]);
    set_new(33, 1'b0, 4'hF); tick();
    edge_skip = 1'b1; set_idle(); wdata = 32'hBAD0BAD0; tick(); tick();
    edge_skip = 1'b0; wdata = 32'h600D600D; tick();
    ref_mem[33] = 32'h600D600D;
    read1("R8 data after skip", 33);

    // selects (R1)
    for (int s = 0; s < 8; s++) begin
      set_new(7, 1'b1, 4'h0);
      {sel_a_n, sel_b, sel_c_n} = 3'(s);
      tick();
      chk("R1 select decode", 32'(q_drv), (s == 3'b010) ? 32'd1 : 32'd0);
      set_idle(); tick();
    end
    set_new(8, 1'b0, 4'hF); sel_c_n = 1'b1; tick();
    set_idle(); wdata = 32'hDEADBEEF; tick();
    read1("R1 deselected write", 8);

    // continue after deselect (R5)
    set_idle(); tick();
    set_cont(4'h0); tick();
    chk("R5 continue after deselect", 32'(q_drv), 32'd0);
    set_cont(4'hF); tick(); wdata = 32'h0BADF00D; set_idle(); tick();
    read1("R5 no stray write", beat_addr(8, 1, 1'b0));

    // async output enable (R10)
    set_new(12, 1'b1, 4'h0); tick();
    out_en_n = 1'b1; #1;
    chk("R10 drive off", 32'(q_drv), 32'd0);
    chk("R10 q zero", q, 32'd0);
    out_en_n = 1'b0; #1;
    chk("R10 drive back", q, ref_mem[12]);
    out_en_n = 1'b1; set_cont(4'h0); tick(); out_en_n = 1'b0; #1;
    chk("R10 state kept", q, ref_mem[13]);
    set_idle(); tick();

    // sleep (R11)
    sleep = 1'b1; set_new(14, 1'b1, 4'h0); tick();
    chk("R11 read ignored", 32'(q_drv), 32'd0);
    set_new(15, 1'b0, 4'hF); tick();
    set_idle(); wdata = 32'h5EE75EE7; tick();
    sleep = 1'b0;
    read1("R11 memory kept", 15);
    set_new(16, 1'b1, 4'h0); tick();
    sleep = 1'b1; set_cont(4'h0); tick();
    chk("R11 burst stopped", 32'(q_drv), 32'd0);
    sleep = 1'b0; set_cont(4'h0); tick();
    chk("R5 continue after sleep", 32'(q_drv), 32'd0);
    set_idle(); tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule